// File: doc/BRIEF.md
# Load/Store Address Generator with Base Writeback

This block forms the memory address of one load or store, the updated base value that the register file writes back in pre-indexed and post-indexed forms, and the address of the second element of a pair access. In the same step it shapes the data: a load's raw memory word becomes a zero-extended or sign-extended register value sized for a 32-bit or 64-bit destination, and a store's data is trimmed to its access size with a matching byte-lane enable mask.

The offset is either an unsigned 12-bit immediate scaled by the access size, an index register (optionally cut to its low 32 bits and zero-extended, optionally shifted left by the log2 of the access size), or a signed 9-bit unscaled immediate. All results are registered once and appear on the cycle after the request, marked by `out_valid`.

Top module: `agu_lsu`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state has `out_valid` = 0 and every data output at zero.
- R2: With `off_sel` = 0 the offset is `uimm` shifted left by `size` (size code 0..3 means 1, 2, 4, 8 bytes), so a 64-bit access reaches base + 32760 and a 32-bit access base + 16380 at `uimm` = 4095.
- R3: With `off_sel` = 1 the offset is `index`, first replaced by its low 32 bits zero-extended when `idx_uxtw` = 1, then shifted left by `size` when `idx_scale` = 1.
- R4: With `off_sel` = 2 the offset is `simm` sign-extended to 64 bits and not scaled; `off_sel` = 3 gives a zero offset.
- R5: Mode code 1 (pre-index) gives `ea` = `wb_val` = base + offset with `wb_en` = 1; mode 2 (post-index) gives `ea` = base, `wb_val` = base + offset, `wb_en` = 1; modes 0 (plain offset) and 3 give `ea` = base + offset with `wb_en` = 0.
- R6: When `pair` = 1, `ea2` = `ea` + 8; otherwise `ea2` = `ea`.
- R7: A byte or halfword load (size 0 or 1) is zero-extended when `ld_signed` = 0; when signed it is sign-extended to 64 bits if `dst64` = 1, or sign-extended to 32 bits with bits 63:32 cleared if `dst64` = 0.
- R8: A word load (size 2) is sign-extended to 64 bits only when `ld_signed` = 1 and `dst64` = 1, otherwise zero-extended; a doubleword load (size 3) passes all 64 bits when `dst64` = 1 and only the zero-extended low word when `dst64` = 0; any load with `dst64` = 0 has bits 63:32 of `ld_result` at zero.
- R9: For a store (`is_load` = 0), `st_data` holds the low 1, 2, 4 or 8 bytes of `wdata` with higher bytes zero and `st_be` has exactly that many low bits set; `ld_result` is zero. For a load, `st_be` and `st_data` are zero.
- R10: Results appear with `out_valid` = 1 on the clock edge after one with `in_valid` = 1; an edge with `in_valid` = 0 drops `out_valid` while the data outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| base | input | 64 | Base register value |
| uimm | input | 12 | Unsigned scaled immediate |
| simm | input | 9 | Signed unscaled immediate |
| index | input | 64 | Index register value |
| off_sel | input | 2 | Offset source: 0 uimm, 1 index, 2 simm, 3 none |
| idx_uxtw | input | 1 | Use low 32 bits of index, zero-extended |
| idx_scale | input | 1 | Shift index left by log2 of access size |
| mode | input | 2 | 0 offset, 1 pre-index, 2 post-index, 3 offset |
| size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 double |
| is_load | input | 1 | 1 load, 0 store |
| ld_signed | input | 1 | Sign-extend loaded value |
| dst64 | input | 1 | Destination is 64 bits wide |
| pair | input | 1 | Pair access |
| rdata | input | 64 | Raw data read from memory |
| wdata | input | 64 | Store data from register |
| out_valid | output | 1 | Outputs carry a new result |
| ea | output | 64 | Effective address of first element |
| ea2 | output | 64 | Address of second element of a pair |
| wb_en | output | 1 | Base writeback enable |
| wb_val | output | 64 | Updated base value |
| ld_result | output | 64 | Extended load value |
| st_data | output | 64 | Size-trimmed store data |
| st_be | output | 8 | Store byte-lane enables |

## Verification
Addresses are tried at the immediate's top value for word and doubleword sizes, which separates a correct scale from a missing or doubled shift, and with an index whose upper half is non-zero, which tells the zero-extend option and the scale option apart. A negative and a positive 9-bit immediate are run through every addressing mode, exposing a swapped pre/post choice, a writeback in offset mode and a missing sign extension. One memory word with its sign bit set at byte, halfword and word positions is loaded under every signedness and destination width, so each extension path yields a distinct value; stores of all four sizes check the lane mask against the trimmed data.

// File: rtl/agu_pkg.sv
// Shared encodings for the load/store address generator.
// Assumes 2-bit codes on all selector inputs.
package agu_pkg;
    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        AM_OFFSET = 2'd0,
        AM_PRE    = 2'd1,
        AM_POST   = 2'd2,
        AM_RSVD   = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        OS_UIMM  = 2'd0,
        OS_INDEX = 2'd1,
        OS_SIMM  = 2'd2,
        OS_NONE  = 2'd3
    } off_src_e;
endpackage

// File: rtl/agu_offset.sv
// Offset former: picks the scaled unsigned immediate, the extended and
// optionally scaled index, or the sign-extended unscaled immediate.
// Assumes AW > 32 so that the 32-bit zero-extend option is meaningful.
module agu_offset
    import agu_pkg::*;
#(
    parameter int AW     = 64,
    parameter int UIMM_W = 12,
    parameter int SIMM_W = 9
) (
    input  logic [UIMM_W-1:0] uimm,
    input  logic [SIMM_W-1:0] simm,
    input  logic [AW-1:0]     index,
    input  off_src_e          src,
    input  logic              idx_uxtw,
    input  logic              idx_scale,
    input  acc_size_e         size,
    output logic [AW-1:0]     offset
);
    localparam int WORD_W = 32;

    logic [AW-1:0] uimm_ext;
    logic [AW-1:0] simm_ext;
    logic [AW-1:0] idx_ext;

    // Widen both immediates and the optionally narrowed index.
    always_comb begin
        uimm_ext = {{(AW-UIMM_W){1'b0}}, uimm};
        simm_ext = {{(AW-SIMM_W){simm[SIMM_W-1]}}, simm};
        idx_ext  = idx_uxtw ? {{(AW-WORD_W){1'b0}}, index[WORD_W-1:0]} : index;
    end

    // Select the offset source and apply the size scale where it belongs.
    always_comb begin
        unique case (src)
            OS_UIMM:  offset = uimm_ext << size;
            OS_INDEX: offset = idx_scale ? (idx_ext << size) : idx_ext;
            OS_SIMM:  offset = simm_ext;
            default:  offset = '0;
        endcase
    end
endmodule

// File: rtl/agu_addr.sv
// Address and writeback former: applies the addressing mode to base and
// offset and derives the pair's second address. Assumes wrap-around adds.
module agu_addr
    import agu_pkg::*;
#(
    parameter int AW          = 64,
    parameter int PAIR_STRIDE = 8
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] offset,
    input  addr_mode_e    mode,
    input  logic          pair,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] ea2,
    output logic          wb_en,
    output logic [AW-1:0] wb_val
);
    logic [AW-1:0] sum;

    // Updated base is always base plus offset; only the mode decides its use.
    always_comb sum = base + offset;

    // Mode decode: post-index accesses the old base, the others the sum.
    always_comb begin
        wb_val = sum;
        unique case (mode)
            AM_PRE:  begin ea = sum;  wb_en = 1'b1; end
            AM_POST: begin ea = base; wb_en = 1'b1; end
            default: begin ea = sum;  wb_en = 1'b0; end
        endcase
    end

    // Second element of a pair follows the first by the register stride.
    always_comb ea2 = pair ? ea + AW'(PAIR_STRIDE) : ea;

    // R5: in post-index the access address must differ from the written base
    // exactly by the offset.
    always_comb begin
        if (mode == AM_POST)
            a_r5_post_gap: assert (wb_val - ea == offset);
    end
endmodule

// File: rtl/agu_data.sv
// Data shaper: extends load data to the destination width and trims store
// data to the access size with a byte-lane mask. Assumes DW = 64.
module agu_data
    import agu_pkg::*;
#(
    parameter int DW = 64
) (
    input  acc_size_e       size,
    input  logic            is_load,
    input  logic            ld_signed,
    input  logic            dst64,
    input  logic [DW-1:0]   rdata,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   ld_result,
    output logic [DW-1:0]   st_data,
    output logic [DW/8-1:0] st_be
);
    localparam int NB   = DW / 8;
    localparam int NB_W = $clog2(NB) + 1;
    localparam int HW   = 32;

    logic [NB_W-1:0] nbytes;
    logic [NB-1:0]   lane_on;
    logic [DW-1:0]   mask;
    logic            sbit;
    logic [DW-1:0]   val_z;
    logic [DW-1:0]   val_s;

    // Byte count of the access.
    always_comb nbytes = NB_W'(1) << size;

    // One enable and one 8-bit mask slice per byte lane.
    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign lane_on[i]         = NB_W'(i) < nbytes;
        assign mask[8*i +: 8]     = {8{lane_on[i]}};
    end

    // Sign bit of the loaded field for each size.
    always_comb begin
        unique case (size)
            SZ_B:    sbit = rdata[7];
            SZ_H:    sbit = rdata[15];
            SZ_W:    sbit = rdata[31];
            default: sbit = rdata[DW-1];
        endcase
    end

    // Zero-extended and fully sign-extended forms of the field.
    always_comb begin
        val_z = rdata & mask;
        val_s = val_z | (sbit ? ~mask : '0);
    end

    // Choose the load result by size, signedness and destination width.
    always_comb begin
        if (!is_load)
            ld_result = '0;
        else if (size == SZ_D)
            ld_result = dst64 ? rdata : {{(DW-HW){1'b0}}, rdata[HW-1:0]};
        else if (!ld_signed)
            ld_result = val_z;
        else if (dst64)
            ld_result = val_s;
        else if (size == SZ_W)
            ld_result = val_z;
        else
            ld_result = {{(DW-HW){1'b0}}, val_s[HW-1:0]};
    end

    // Store side: trimmed data and lane enables, silent for loads.
    always_comb begin
        st_data = is_load ? '0 : (wdata & mask);
        st_be   = is_load ? '0 : lane_on;
    end

    // R8: a narrow destination never carries upper bits.
    always_comb begin
        if (is_load && !dst64)
            a_r8_dst32_upper_zero: assert (ld_result[DW-1:HW] == '0);
    end

    // R9: store lane count matches the access size.
    always_comb begin
        if (!is_load)
            a_r9_be_count: assert ($countones(st_be) == int'(nbytes));
    end
endmodule

// File: rtl/agu_lsu.sv
// Top of the load/store address generator: forms the offset, applies the
// addressing mode, shapes the data and registers all results one cycle.
// Synchronous active-low reset; outputs hold while no request arrives.
module agu_lsu
    import agu_pkg::*;
#(
    parameter int AW          = 64,
    parameter int DW          = 64,
    parameter int UIMM_W      = 12,
    parameter int SIMM_W      = 9,
    parameter int PAIR_STRIDE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [AW-1:0]     base,
    input  logic [UIMM_W-1:0] uimm,
    input  logic [SIMM_W-1:0] simm,
    input  logic [AW-1:0]     index,
    input  logic [1:0]        off_sel,
    input  logic              idx_uxtw,
    input  logic              idx_scale,
    input  logic [1:0]        mode,
    input  logic [1:0]        size,
    input  logic              is_load,
    input  logic              ld_signed,
    input  logic              dst64,
    input  logic              pair,
    input  logic [DW-1:0]     rdata,
    input  logic [DW-1:0]     wdata,
    output logic              out_valid,
    output logic [AW-1:0]     ea,
    output logic [AW-1:0]     ea2,
    output logic              wb_en,
    output logic [AW-1:0]     wb_val,
    output logic [DW-1:0]     ld_result,
    output logic [DW-1:0]     st_data,
    output logic [DW/8-1:0]   st_be
);
    localparam int NB = DW / 8;

    logic [AW-1:0] offset_c;
    logic [AW-1:0] ea_c, ea2_c, wb_val_c;
    logic          wb_en_c;
    logic [DW-1:0] ld_c, st_c;
    logic [NB-1:0] be_c;

    agu_offset #(.AW(AW), .UIMM_W(UIMM_W), .SIMM_W(SIMM_W)) u_off (
        .uimm      (uimm),
        .simm      (simm),
        .index     (index),
        .src       (off_src_e'(off_sel)),
        .idx_uxtw  (idx_uxtw),
        .idx_scale (idx_scale),
        .size      (acc_size_e'(size)),
        .offset    (offset_c)
    );

    agu_addr #(.AW(AW), .PAIR_STRIDE(PAIR_STRIDE)) u_addr (
        .base   (base),
        .offset (offset_c),
        .mode   (addr_mode_e'(mode)),
        .pair   (pair),
        .ea     (ea_c),
        .ea2    (ea2_c),
        .wb_en  (wb_en_c),
        .wb_val (wb_val_c)
    );

    agu_data #(.DW(DW)) u_data (
        .size      (acc_size_e'(size)),
        .is_load   (is_load),
        .ld_signed (ld_signed),
        .dst64     (dst64),
        .rdata     (rdata),
        .wdata     (wdata),
        .ld_result (ld_c),
        .st_data   (st_c),
        .st_be     (be_c)
    );

    // Output register: clear on reset, capture on a request, else hold data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            ea        <= '0;
            ea2       <= '0;
            wb_en     <= 1'b0;
            wb_val    <= '0;
            ld_result <= '0;
            st_data   <= '0;
            st_be     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                ea        <= ea_c;
                ea2       <= ea2_c;
                wb_en     <= wb_en_c;
                wb_val    <= wb_val_c;
                ld_result <= ld_c;
                st_data   <= st_c;
                st_be     <= be_c;
            end
        end
    end

    // R1: reset empties the output stage.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !out_valid && ea == '0 && st_be == '0);

    // R10: a request yields a valid result one cycle later.
    a_r10_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10: no request, no valid, and data holds.
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(ea) && $stable(wb_val));

    // R5: post-index accesses the base that came in.
    a_r5_post_old_base: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && mode == 2'd2 |=> ea == $past(base) && wb_en);

    // R5: plain offset mode never writes the base back.
    a_r5_no_wb_offset: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && mode == 2'd0 |=> !wb_en);

    // R6: pair second address follows the first by the stride.
    a_r6_pair_stride: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && pair |=> ea2 == ea + AW'(PAIR_STRIDE));
endmodule

// File: tb/agu_lsu_test.sv
`timescale 1ns/1ps
module agu_lsu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] base = '0;
    logic [11:0] uimm = '0;
    logic [8:0]  simm = '0;
    logic [63:0] index = '0;
    logic [1:0]  off_sel = '0;
    logic        idx_uxtw = 1'b0;
    logic        idx_scale = 1'b0;
    logic [1:0]  mode = '0;
    logic [1:0]  size = '0;
    logic        is_load = 1'b1;
    logic        ld_signed = 1'b0;
    logic        dst64 = 1'b1;
    logic        pair = 1'b0;
    logic [63:0] rdata = '0;
    logic [63:0] wdata = '0;
    logic        out_valid;
    logic [63:0] ea, ea2, wb_val, ld_result, st_data;
    logic        wb_en;
    logic [7:0]  st_be;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    agu_lsu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base(base),
        .uimm(uimm), .simm(simm), .index(index), .off_sel(off_sel),
        .idx_uxtw(idx_uxtw), .idx_scale(idx_scale), .mode(mode), .size(size),
        .is_load(is_load), .ld_signed(ld_signed), .dst64(dst64), .pair(pair),
        .rdata(rdata), .wdata(wdata), .out_valid(out_valid), .ea(ea),
        .ea2(ea2), .wb_en(wb_en), .wb_val(wb_val), .ld_result(ld_result),
        .st_data(st_data), .st_be(st_be)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present the request just after an edge, capture at the next edge,
    // and leave the outputs to be read 1 ns after it.
    task automatic issue();
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 out_valid", {63'b0, out_valid}, 64'd0);
        check("R1 ea", ea, 64'd0);
        check("R1 st_be", {56'b0, st_be}, 64'd0);
    endtask

    task automatic t_uimm();
        off_sel = 2'd0; mode = 2'd0; base = 64'h1000; uimm = 12'd4095;
        size = 2'd3; issue();
        check("R2 dword max", ea, 64'h8FF8);
        check("R10 valid", {63'b0, out_valid}, 64'd1);
        size = 2'd2; issue();
        check("R2 word max", ea, 64'h4FFC);
        size = 2'd0; uimm = 12'd5; issue();
        check("R2 byte", ea, 64'h1005);
    endtask

    task automatic t_index();
        off_sel = 2'd1; mode = 2'd0; base = 64'h1000; size = 2'd3;
        index = 64'd3; idx_uxtw = 1'b0; idx_scale = 1'b1; issue();
        check("R3 scaled", ea, 64'h1018);
        idx_scale = 1'b0; issue();
        check("R3 unscaled", ea, 64'h1003);
        index = 64'hFFFF_FFFF_0000_0004; idx_uxtw = 1'b1; idx_scale = 1'b1; issue();
        check("R3 uxtw scaled", ea, 64'h1020);
        idx_uxtw = 1'b0; idx_scale = 1'b0; issue();
        check("R3 full index", ea, 64'hFFFF_FFFF_0000_1004);
    endtask

    task automatic t_modes();
        off_sel = 2'd2; base = 64'h2000; simm = 9'h1F0; mode = 2'd1; issue();
        check("R4 R5 pre ea", ea, 64'h1FF0);
        check("R5 pre wb", wb_val, 64'h1FF0);
        check("R5 pre wb_en", {63'b0, wb_en}, 64'd1);
        simm = 9'd16; mode = 2'd2; issue();
        check("R5 post ea", ea, 64'h2000);
        check("R5 post wb", wb_val, 64'h2010);
        check("R5 post wb_en", {63'b0, wb_en}, 64'd1);
        mode = 2'd0; issue();
        check("R5 offset ea", ea, 64'h2010);
        check("R5 offset wb_en", {63'b0, wb_en}, 64'd0);
        mode = 2'd3; issue();
        check("R5 mode3 wb_en", {63'b0, wb_en}, 64'd0);
        off_sel = 2'd3; mode = 2'd0; issue();
        check("R4 no offset", ea, 64'h2000);
    endtask

    task automatic t_pair();
        off_sel = 2'd2; base = 64'h3000; simm = 9'h1F0; mode = 2'd1; pair = 1'b1; issue();
        check("R6 pair ea", ea, 64'h2FF0);
        check("R6 pair ea2", ea2, 64'h2FF8);
        pair = 1'b0; issue();
        check("R6 single ea2", ea2, 64'h2FF0);
    endtask

    task automatic t_load();
        is_load = 1'b1; rdata = 64'h1234_5678_9ABC_DE80;
        size = 2'd0; ld_signed = 1'b0; dst64 = 1'b1; issue();
        check("R7 byte zext", ld_result, 64'h80);
        ld_signed = 1'b1; dst64 = 1'b0; issue();
        check("R7 byte sext32", ld_result, 64'h0000_0000_FFFF_FF80);
        dst64 = 1'b1; issue();
        check("R7 byte sext64", ld_result, 64'hFFFF_FFFF_FFFF_FF80);
        size = 2'd1; issue();
        check("R7 half sext64", ld_result, 64'hFFFF_FFFF_FFFF_DE80);
        ld_signed = 1'b0; issue();
        check("R7 half zext", ld_result, 64'hDE80);
        size = 2'd2; issue();
        check("R8 word zext", ld_result, 64'h9ABC_DE80);
        ld_signed = 1'b1; issue();
        check("R8 word sext64", ld_result, 64'hFFFF_FFFF_9ABC_DE80);
        dst64 = 1'b0; issue();
        check("R8 word dst32", ld_result, 64'h9ABC_DE80);
        size = 2'd3; ld_signed = 1'b0; dst64 = 1'b1; issue();
        check("R8 dword", ld_result, 64'h1234_5678_9ABC_DE80);
        dst64 = 1'b0; issue();
        check("R8 dword dst32", ld_result, 64'h9ABC_DE80);
        check("R9 load no be", {56'b0, st_be}, 64'd0);
        check("R9 load no data", st_data, 64'd0);
        dst64 = 1'b1;
    endtask

    task automatic t_store();
        is_load = 1'b0; wdata = 64'h1122_3344_5566_7788;
        size = 2'd0; issue();
        check("R9 byte data", st_data, 64'h88);
        check("R9 byte be", {56'b0, st_be}, 64'h01);
        check("R9 store ld zero", ld_result, 64'd0);
        size = 2'd1; issue();
        check("R9 half data", st_data, 64'h7788);
        check("R9 half be", {56'b0, st_be}, 64'h03);
        size = 2'd2; issue();
        check("R9 word data", st_data, 64'h5566_7788);
        check("R9 word be", {56'b0, st_be}, 64'h0F);
        size = 2'd3; issue();
        check("R9 dword data", st_data, 64'h1122_3344_5566_7788);
        check("R9 dword be", {56'b0, st_be}, 64'hFF);
        is_load = 1'b1;
    endtask

    task automatic t_idle();
        base = 64'h5000; off_sel = 2'd3; mode = 2'd0; issue();
        check("R10 valid after req", {63'b0, out_valid}, 64'd1);
        base = 64'h6000;
        @(posedge clk); #1;
        check("R10 valid drops", {63'b0, out_valid}, 64'd0);
        check("R10 data holds", ea, 64'h5000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_uimm();
        t_index();
        t_modes();
        t_pair();
        t_load();
        t_store();
        t_idle();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule